// File: doc/BRIEF.md
# SD Command Frame Transmitter

This block turns a command index and a 32-bit argument into a complete 48-bit command frame for the command line of an SD card, and shifts that frame out serially. A narrow write-only register port is used to set it up: four byte-wide argument registers, and one index register. A write to the index register starts the frame. The block adds the start and direction bits itself. It computes the CRC7 checksum while the header is being shifted out, then sends the checksum and a closing end bit. While a frame is in flight a busy flag is raised. When idle, the line rests high.

The checksum is not computed ahead of time. A serial CRC accumulator absorbs each header bit in the same cycle that the bit leaves the block. After 40 bits the accumulator holds the finished remainder. It then becomes a shift register and drains the remainder onto the line. The argument registers keep their values from one frame to the next, so a repeated command only needs an index write.

Top module: `sd_cmd_tx`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves `busy` low and `cmd_out` high, and clears all four argument registers to zero.
- R2: A write (`bus_sel` high at a rising edge) to address 0, 1, 2 or 3 stores `bus_wdata` into argument bits [7:0], [15:8], [23:16] or [31:24] respectively.
- R3: A write to address 4 while idle starts a frame. From that edge on, `busy` is high and `cmd_out` shows frame bit 47.
- R4: The frame, from bit 47 down to bit 0, is laid out as follows: a 0 start bit, a 1 direction bit, the index taken from `bus_wdata[5:0]` (bits 7:6 ignored), the 32-bit argument, the 7-bit CRC, and a 1 end bit.
- R5: The CRC is the remainder of the 40 header bits over the polynomial x^7 + x^3 + 1, starting from zero. Examples: index 0 with argument 0 gives 0x400000000095, and index 8 with argument 0x1AA gives 0x48000001AA87. Index 55 with argument 0 gives 0x770000000065, and index 41 with argument 0x40180000 gives 0x694018000019.
- R6: The frame goes out most significant bit first, one bit per clock. `busy` stays high for exactly 48 cycles and then falls.
- R7: While `busy` is low, `cmd_out` is 1.
- R8: A write to address 4 while busy is ignored. The frame in flight is unchanged and its length is not extended.
- R9: Cycles with `bus_sel` low change no register and start no frame, whatever the address and data.
- R10: Argument registers keep their value across frames. A write to them during a frame does not change the frame in flight, but it is used by the next frame.
- R11: A reset during a frame stops it at once. After that edge, `busy` is low and `cmd_out` is high.
- R12: Writes to addresses 5 through 15 have no effect. They change no argument and start no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Write strobe; a write happens at each edge where it is high |
| bus_addr | input | 4 | Register address of the write |
| bus_wdata | input | 8 | Write data |
| cmd_out | output | 1 | Serial command line, idles high |
| busy | output | 1 | High while a frame is being sent |

## Verification
The hardest case to reach is an index write or argument write that arrives in the middle of a frame. Such a write has to land on a chosen bit of the 48, and its only visible effect is that nothing changes. The bench's capture loop therefore drives a write on a chosen bit while it keeps recording the line. It then compares the whole captured frame with the expected one. It follows this with a frame that uses only an index write, which shows that the argument write landed in the register. A reset asserted on bit 20 of a frame, followed by a frame with all-zero argument, covers both the abort and the clearing of the registers.

// File: rtl/sdtx_pkg.sv
package sdtx_pkg;

  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ARG_W    = 32;
  localparam int unsigned IDX_W    = 6;
  localparam int unsigned CRC_W    = 7;
  localparam int unsigned HDR_W    = 2 + IDX_W + ARG_W;
  localparam int unsigned FRAME_W  = HDR_W + CRC_W + 1;
  localparam int unsigned IDX_ADDR = ARG_W / DATA_W;
  localparam logic [CRC_W-1:0] CRC_TAPS = 7'h09;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_CRC  = 2'd2,
    PH_STOP = 2'd3
  } phase_e;

  // One serial step of the CRC7 accumulator (Galois form).
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] crc,
                                                 input logic din);
    logic fb;
    fb = din ^ crc[CRC_W-1];
    return {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
  endfunction

  // Header: start bit, direction bit, index, argument.
  function automatic logic [HDR_W-1:0] make_header(input logic [IDX_W-1:0] idx,
                                                   input logic [ARG_W-1:0] arg);
    return {1'b0, 1'b1, idx, arg};
  endfunction

endpackage

// File: rtl/sdtx_regs.sv
module sdtx_regs #(
  parameter int unsigned ADDR_W   = sdtx_pkg::ADDR_W,
  parameter int unsigned DATA_W   = sdtx_pkg::DATA_W,
  parameter int unsigned ARG_W    = sdtx_pkg::ARG_W,
  parameter int unsigned IDX_W    = sdtx_pkg::IDX_W,
  parameter int unsigned IDX_ADDR = sdtx_pkg::IDX_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output logic [ARG_W-1:0]  arg_q,
  output logic              launch,
  output logic [IDX_W-1:0]  launch_idx
);

  localparam int unsigned LANES = ARG_W / DATA_W;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic hit;
    assign hit = sel && (addr == ADDR_W'(b));
    always_ff @(posedge clk) begin
      if (rst)      arg_q[b*DATA_W +: DATA_W] <= '0;
      else if (hit) arg_q[b*DATA_W +: DATA_W] <= wdata;
    end
  end

  assign launch     = sel && (addr == ADDR_W'(IDX_ADDR)) && !busy;
  assign launch_idx = wdata[IDX_W-1:0];

endmodule

// File: rtl/sdtx_crc7.sv
module sdtx_crc7 #(
  parameter int unsigned CRC_W = sdtx_pkg::CRC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             absorb,
  input  logic             drain,
  input  logic             din,
  output logic             crc_msb,
  output logic [CRC_W-1:0] crc_q
);

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= '0;
    else if (absorb)  crc_q <= sdtx_pkg::crc7_step(crc_q, din);
    else if (drain)   crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end

  assign crc_msb = crc_q[CRC_W-1];

endmodule

// File: rtl/sdtx_shifter.sv
module sdtx_shifter #(
  parameter int unsigned HDR_W = sdtx_pkg::HDR_W,
  parameter int unsigned CRC_W = sdtx_pkg::CRC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                launch,
  input  logic [HDR_W-1:0]    launch_hdr,
  output sdtx_pkg::phase_e    phase,
  output logic                hdr_msb,
  output logic                busy
);
  import sdtx_pkg::*;

  localparam int unsigned CNT_W = $clog2(HDR_W);

  logic [HDR_W-1:0] hdr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
      hdr_q <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (launch) begin
          phase <= PH_HDR;
          cnt_q <= '0;
          hdr_q <= launch_hdr;
        end
        PH_HDR: begin
          hdr_q <= {hdr_q[HDR_W-2:0], 1'b0};
          if (cnt_q == CNT_W'(HDR_W - 1)) begin
            phase <= PH_CRC;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CRC: begin
          if (cnt_q == CNT_W'(CRC_W - 1)) begin
            phase <= PH_STOP;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_STOP: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign hdr_msb = hdr_q[HDR_W-1];
  assign busy    = (phase != PH_IDLE);

endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx #(
  parameter int unsigned ADDR_W = sdtx_pkg::ADDR_W,
  parameter int unsigned DATA_W = sdtx_pkg::DATA_W,
  parameter int unsigned ARG_W  = sdtx_pkg::ARG_W,
  parameter int unsigned IDX_W  = sdtx_pkg::IDX_W,
  parameter int unsigned CRC_W  = sdtx_pkg::CRC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              cmd_out,
  output logic              busy
);
  import sdtx_pkg::*;

  localparam int unsigned HDR_W    = 2 + IDX_W + ARG_W;
  localparam int unsigned IDX_ADDR = ARG_W / DATA_W;

  // Named internal events, visible to the bound checker.
  logic             launch_w;
  logic [IDX_W-1:0] launch_idx_w;
  logic [ARG_W-1:0] arg_w;
  phase_e           phase_w;
  logic             hdr_bit_w;
  logic             crc_bit_w;
  logic [CRC_W-1:0] crc_w;
  logic             crc_absorb_w;
  logic             crc_drain_w;

  sdtx_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARG_W(ARG_W),
    .IDX_W(IDX_W), .IDX_ADDR(IDX_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .addr(bus_addr), .wdata(bus_wdata),
    .busy(busy), .arg_q(arg_w), .launch(launch_w), .launch_idx(launch_idx_w)
  );

  sdtx_shifter #(.HDR_W(HDR_W), .CRC_W(CRC_W)) u_shift (
    .clk(clk), .rst(rst), .launch(launch_w),
    .launch_hdr({1'b0, 1'b1, launch_idx_w, arg_w}),
    .phase(phase_w), .hdr_msb(hdr_bit_w), .busy(busy)
  );

  assign crc_absorb_w = (phase_w == PH_HDR);
  assign crc_drain_w  = (phase_w == PH_CRC);

  sdtx_crc7 #(.CRC_W(CRC_W)) u_crc (
    .clk(clk), .rst(rst), .clear(launch_w), .absorb(crc_absorb_w),
    .drain(crc_drain_w), .din(hdr_bit_w), .crc_msb(crc_bit_w), .crc_q(crc_w)
  );

  always_comb begin
    unique case (phase_w)
      PH_HDR:  cmd_out = hdr_bit_w;
      PH_CRC:  cmd_out = crc_bit_w;
      default: cmd_out = 1'b1;
    endcase
  end

endmodule

// File: rtl/sd_cmd_tx_chk.sv
module sd_cmd_tx_chk #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned FRAME_W  = 48,
  parameter int unsigned IDX_ADDR = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              cmd_out,
  input logic              busy
);

  logic [7:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= '0;
    else              run_cnt <= run_cnt + 1'b1;
  end

  // R1 / R11: reset lands in idle with the line high
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!busy && cmd_out));

  // R7: line is high whenever idle
  a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cmd_out);

  // R3: an index write while idle starts the frame with the start bit
  a_r3_start: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_addr == ADDR_W'(IDX_ADDR) && !busy) |=> (busy && !cmd_out));

  // R4: direction bit follows the start bit; end bit closes the frame
  a_r4_dir_bit: assert property (@(posedge clk) disable iff (rst)
    (busy && run_cnt == 8'd1) |-> cmd_out);
  a_r4_end_bit: assert property (@(posedge clk) disable iff (rst)
    (busy && run_cnt == 8'(FRAME_W - 1)) |-> cmd_out);

  // R6 / R8: busy lasts exactly FRAME_W cycles, even with index writes inside
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && run_cnt < 8'(FRAME_W - 1)) |=> busy);
  a_r6_end: assert property (@(posedge clk) disable iff (rst)
    (busy && run_cnt == 8'(FRAME_W - 1)) |=> !busy);

  // R9: no strobe, no start
  a_r9_no_sel: assert property (@(posedge clk) disable iff (rst)
    (!bus_sel && !busy) |=> !busy);

  // R12: unmapped addresses start nothing
  a_r12_unmapped: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_addr > ADDR_W'(IDX_ADDR) && !busy) |=> !busy);

endmodule

bind sd_cmd_tx sd_cmd_tx_chk #(
  .ADDR_W(ADDR_W), .FRAME_W(HDR_W + CRC_W + 1), .IDX_ADDR(IDX_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
  .cmd_out(cmd_out), .busy(busy)
);

// File: tb/test_sd_cmd_tx.sv
module test_sd_cmd_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       cmd_out;
  logic       busy;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] cur_arg;

  always #5 clk = ~clk;

  sd_cmd_tx i_sd_cmd_tx (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cmd_out(cmd_out), .busy(busy)
  );

  // Expected frame by polynomial long division over x^7 + x^3 + 1 (R4, R5)
  function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] hdr;
    logic [46:0] v;
    hdr = {2'b01, idx, arg};
    v = {hdr, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'h89;
    return {hdr, v[6:0], 1'b1};
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic load_arg(input logic [31:0] arg);
    for (int b = 0; b < 4; b++) wr(4'(b), arg[b*8 +: 8]);
    cur_arg = arg;
  endtask

  // Capture 48 bits starting at the negedge after the launch edge.
  // Optionally drives one write while bit inj_k is on the line.
  task automatic capture(output logic [47:0] got, output bit len_ok, input int inj_k,
                         input logic [3:0] inj_a, input logic [7:0] inj_d);
    len_ok = 1'b1;
    for (int k = 0; k < 48; k++) begin
      if (busy !== 1'b1) len_ok = 1'b0;
      got[47-k] = cmd_out;
      if (k == inj_k) begin bus_sel = 1'b1; bus_addr = inj_a; bus_wdata = inj_d; end
      @(negedge clk);
      bus_sel = 1'b0;
    end
    if (busy !== 1'b0 || cmd_out !== 1'b1) len_ok = 1'b0;
  endtask

  task automatic frame(input logic [5:0] idx, input logic [47:0] exp, input string req,
                       input int inj_k, input logic [3:0] inj_a, input logic [7:0] inj_d);
    logic [47:0] got;
    bit len_ok;
    wr(4'd4, {idx[1:0], idx});
    capture(got, len_ok, inj_k, inj_a, inj_d);
    check(got === exp, req, got, exp);
    check(len_ok, "R6 busy length / R7 idle line", {47'b0, busy}, 48'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(busy === 1'b0 && cmd_out === 1'b1, "R1 reset state",
          {46'b0, busy, cmd_out}, 48'd1);
    cur_arg = '0;

    // R5: published example frames
    load_arg(32'h0);        frame(6'd0,  48'h400000000095, "R5 idx0", -1, 4'd0, 8'd0);
    load_arg(32'h1AA);      frame(6'd8,  48'h48000001AA87, "R5 idx8", -1, 4'd0, 8'd0);
    load_arg(32'h0);        frame(6'd55, 48'h770000000065, "R5 idx55", -1, 4'd0, 8'd0);
    load_arg(32'h40180000); frame(6'd41, 48'h694018000019, "R5 idx41", -1, 4'd0, 8'd0);

    // R2 R4 R6: sweep every index with varied arguments
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a;
      a = (32'h9E3779B9 * (i + 1)) ^ (32'h1 << (i % 32));
      load_arg(a);
      frame(6'(i), exp_frame(6'(i), a), "R2/R4 sweep", -1, 4'd0, 8'd0);
      if (i % 8 == 0) begin
        load_arg(32'hFFFFFFFF);
        frame(6'(i), exp_frame(6'(i), 32'hFFFFFFFF), "R4 all-ones arg", -1, 4'd0, 8'd0);
      end
    end

    // R8: index write mid-frame is ignored
    load_arg(32'h1AA);
    frame(6'd8, 48'h48000001AA87, "R8 index write while busy", 10, 4'd4, 8'd55);
    frame(6'd8, 48'h48000001AA87, "R8 index write on last bit", 47, 4'd4, 8'd41);

    // R10: argument write mid-frame affects only the next frame
    frame(6'd8, 48'h48000001AA87, "R10 frame in flight unchanged", 5, 4'd0, 8'h55);
    cur_arg[7:0] = 8'h55;
    frame(6'd8, exp_frame(6'd8, cur_arg), "R10 next frame uses new byte", -1, 4'd0, 8'd0);
    frame(6'd17, exp_frame(6'd17, cur_arg), "R10 retention", -1, 4'd0, 8'd0);

    // R9: strobe low changes nothing
    @(negedge clk);
    bus_sel = 1'b0; bus_addr = 4'd4; bus_wdata = 8'd9;
    @(negedge clk);
    check(busy === 1'b0 && cmd_out === 1'b1, "R9 no start without sel",
          {46'b0, busy, cmd_out}, 48'd1);
    bus_addr = 4'd0; bus_wdata = 8'hEE;
    @(negedge clk);
    frame(6'd2, exp_frame(6'd2, cur_arg), "R9 arg unchanged without sel", -1, 4'd0, 8'd0);

    // R12: unmapped addresses
    for (int a = 5; a < 16; a++) begin
      wr(4'(a), 8'hA5);
      check(busy === 1'b0 && cmd_out === 1'b1, "R12 unmapped no start",
            {46'b0, busy, cmd_out}, 48'd1);
    end
    frame(6'd3, exp_frame(6'd3, cur_arg), "R12 args untouched", -1, 4'd0, 8'd0);

    // R11: reset mid-frame, then R1 argument clearing
    load_arg(32'h12345678);
    wr(4'd4, 8'd8);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0 && cmd_out === 1'b1, "R11 abort to idle",
          {46'b0, busy, cmd_out}, 48'd1);
    cur_arg = '0;
    frame(6'd0, 48'h400000000095, "R1 args cleared by reset", -1, 4'd0, 8'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule